// File: doc/BRIEF.md
# Coprocessor Memory Access Unit

This block carries out every bus access of a small 8-bit sound coprocessor core over a 16-bit address space. Each cycle the core names one operation: an instruction or operand fetch, a direct-page read or write, an absolute read or write, a stack push or pop, an idle bus cycle, or no bus cycle at all. The unit forms the effective address from the program counter, the stack pointer or the supplied operand. It picks the read source from three candidates: the 16-byte register window, the 64-byte boot ROM overlay, or main RAM. It returns the byte combinationally in the same cycle. It always stores written bytes into RAM.

The unit owns the program counter, the stack pointer and the boot-overlay enable bit. It also paces the rest of the subsystem. Every bus cycle, idle ones included, pulses a tick to each timer channel. The same cycle removes a fixed amount from a signed credit counter. The downstream audio engine watches the counter's sign to decide when it must catch up, and returns credit through an add input.

Top module: `coproc_mau`

## Requirements
- R1: After a synchronous reset the program counter is 0xFFC0, the stack pointer is 0xEF, the boot overlay is enabled, all tick outputs are 0 and the sync request is 0.
- R2: A read whose effective address lies in 0x00F0..0x00FF returns `mmio_rdata_i` in the same cycle, asserts `mmio_re_o` and drives `mmio_idx_o` with address bits 3:0. Reads elsewhere leave `mmio_re_o` low.
- R3: A read whose effective address is 0xFFC0 or higher returns the boot byte ((i*7) mod 256) XOR 0x5A, where i is address bits 5:0. This holds only while the overlay is enabled; otherwise RAM is read.
- R4: Every write stores `wdata_i` into RAM, including writes in the register window and under the boot overlay. A write in the window also asserts `mmio_we_o` in the same cycle, with `mmio_wdata_o` equal to the written byte.
- R5: Direct-page ops (op 3 read, op 4 write) use address (`dp_page_i` * 256) + `addr_i[7:0]`. Absolute ops (op 5 read, op 6 write) use `addr_i`.
- R6: Push (op 7) writes at 0x0100 | SP and then decrements SP. Pop (op 8) increments SP and then reads at 0x0100 | SP.
- R7: Fetch (op 2) reads at PC, and PC becomes PC+1 after the edge. `pc_load_i` replaces the next PC with `pc_val_i`.
- R8: SP is 8 bits and wraps modulo 256, so stack accesses stay in 0x0100..0x01FF. `sp_load_i` replaces the next SP with `sp_val_i`.
- R9: Each bus cycle (ops 1..8, where op 1 is idle) makes every bit of `tick_o` 1 in the following cycle. Op 0 and ops 9..15 are no bus cycle: they make `tick_o` 0 and leave RAM, PC and SP untouched.
- R10: The credit counter is 16-bit signed and resets to 0. Each cycle it loses 24 if the cycle is a bus cycle and gains `credit_add_i`. `sync_req_o` is 1 exactly while the counter is negative.
- R11: RAM holds 2048 bytes indexed by address bits 10:0, so addresses that differ only in bits 15:11 share a byte.
- R12: `boot_we_i` loads `boot_val_i` into the overlay enable bit, visible on `boot_en_o` and in read selection from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code for this cycle |
| addr_i | input | 16 | Absolute address; bits 7:0 give the direct-page offset |
| dp_page_i | input | 1 | Direct-page select (page 0x00 or 0x01) |
| wdata_i | input | 8 | Write / push data |
| pc_load_i | input | 1 | Load program counter |
| pc_val_i | input | 16 | Program counter load value |
| sp_load_i | input | 1 | Load stack pointer |
| sp_val_i | input | 8 | Stack pointer load value |
| boot_we_i | input | 1 | Write boot overlay enable |
| boot_val_i | input | 1 | New boot overlay enable value |
| credit_add_i | input | 16 | Signed credit returned this cycle |
| mmio_rdata_i | input | 8 | Register window read data (combinational) |
| rdata_o | output | 8 | Read data to the core, same cycle |
| addr_o | output | 16 | Effective address of the current access |
| mmio_re_o | output | 1 | Register window read strobe |
| mmio_we_o | output | 1 | Register window write strobe |
| mmio_idx_o | output | 4 | Register index inside the window |
| mmio_wdata_o | output | 8 | Register window write data |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| boot_en_o | output | 1 | Boot overlay enable |
| tick_o | output | 3 | One tick pulse per timer channel |
| sync_req_o | output | 1 | Credit counter negative |

## Verification
Read data, the effective address and the register-window strobes and write data are combinational. The bench therefore samples them one time step after it drives an operation at the falling edge, while the request is still held. PC, SP, the overlay enable, the tick pulses and the sync request come from registers. These are sampled one time step after the rising edge that takes the request, which is one cycle after the stimulus. RAM writes are observed only through later reads, at least one cycle after the writing edge.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_IDLE   = 4'd1,
    OP_FETCH  = 4'd2,
    OP_DP_RD  = 4'd3,
    OP_DP_WR  = 4'd4,
    OP_ABS_RD = 4'd5,
    OP_ABS_WR = 4'd6,
    OP_PUSH   = 4'd7,
    OP_POP    = 4'd8
  } mau_op_e;

  // register window: upper address bits equal this tag
  localparam logic [11:0] WIN_TAG16 = 12'h00F;

  // computed boot overlay contents
  function automatic logic [7:0] boot_byte(input logic [5:0] idx);
    return ({2'b00, idx} * 8'd7) ^ 8'h5A;
  endfunction

endpackage

// File: rtl/mau_addr.sv
module mau_addr
  import mau_pkg::*;
#(
  parameter int AW = 16,
  parameter int SPW = 8,
  parameter logic [AW-1:0] RST_PC = 'hFFC0,
  parameter logic [SPW-1:0] RST_SP = 'hEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     op_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           dp_page_i,
  input  logic           pc_load_i,
  input  logic [AW-1:0]  pc_val_i,
  input  logic           sp_load_i,
  input  logic [SPW-1:0] sp_val_i,
  output logic [AW-1:0]  ea_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic           bus_o,
  output logic [AW-1:0]  pc_o,
  output logic [SPW-1:0] sp_o
);

  localparam int OFFW = 8;
  localparam int PGW  = AW - SPW;
  localparam logic [PGW-1:0] STACK_PG = PGW'(1);

  mau_op_e        op;
  logic [AW-1:0]  pc_q, pc_n, dp_ea;
  logic [SPW-1:0] sp_q, sp_n, sp_up;

  assign op    = mau_op_e'(op_i);
  assign dp_ea = {{(AW-OFFW-1){1'b0}}, dp_page_i, addr_i[OFFW-1:0]};
  assign sp_up = sp_q + 1'b1;

  always_comb begin
    ea_o  = addr_i;
    rd_o  = 1'b0;
    wr_o  = 1'b0;
    bus_o = 1'b1;
    pc_n  = pc_q;
    sp_n  = sp_q;
    case (op)
      OP_IDLE:   ;
      OP_FETCH:  begin ea_o = pc_q; rd_o = 1'b1; pc_n = pc_q + 1'b1; end
      OP_DP_RD:  begin ea_o = dp_ea; rd_o = 1'b1; end
      OP_DP_WR:  begin ea_o = dp_ea; wr_o = 1'b1; end
      OP_ABS_RD: rd_o = 1'b1;
      OP_ABS_WR: wr_o = 1'b1;
      OP_PUSH:   begin ea_o = {STACK_PG, sp_q}; wr_o = 1'b1; sp_n = sp_q - 1'b1; end
      OP_POP:    begin ea_o = {STACK_PG, sp_up}; rd_o = 1'b1; sp_n = sp_up; end
      default:   bus_o = 1'b0;
    endcase
    if (pc_load_i) pc_n = pc_val_i;
    if (sp_load_i) sp_n = sp_val_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RST_PC;
      sp_q <= RST_SP;
    end else begin
      pc_q <= pc_n;
      sp_q <= sp_n;
    end
  end

  assign pc_o = pc_q;
  assign sp_o = sp_q;

endmodule

// File: rtl/mau_store.sv
module mau_store
  import mau_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RAM_AW = 11
) (
  input  logic          clk,
  input  logic [AW-1:0] ea_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          boot_en_i,
  input  logic [DW-1:0] mmio_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          mmio_re_o,
  output logic          mmio_we_o,
  output logic [3:0]    mmio_idx_o,
  output logic [DW-1:0] mmio_wdata_o
);

  localparam int DEPTH  = 2 ** RAM_AW;
  localparam int TAGW   = AW - 4;
  localparam int ROM_N  = 64;
  localparam logic [TAGW-1:0] WIN_TAG = TAGW'(WIN_TAG16);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rom_tbl [ROM_N];
  logic [DW-1:0] ram_q;
  logic          win_hit, boot_hit;

  // all writes land in RAM, window and overlay included
  always_ff @(posedge clk) begin
    if (wr_i) mem[ea_i[RAM_AW-1:0]] <= wdata_i;
  end
  assign ram_q = mem[ea_i[RAM_AW-1:0]];

  for (genvar g = 0; g < ROM_N; g++) begin : g_rom
    assign rom_tbl[g] = DW'(boot_byte(6'(g)));
  end

  assign win_hit  = (ea_i[AW-1:4] == WIN_TAG);
  assign boot_hit = &ea_i[AW-1:6];

  always_comb begin
    if (win_hit)                    rdata_o = mmio_rdata_i;
    else if (boot_hit && boot_en_i) rdata_o = rom_tbl[ea_i[5:0]];
    else                            rdata_o = ram_q;
  end

  assign mmio_re_o    = rd_i & win_hit;
  assign mmio_we_o    = wr_i & win_hit;
  assign mmio_idx_o   = ea_i[3:0];
  assign mmio_wdata_o = wdata_i;

endmodule

// File: rtl/mau_pace.sv
module mau_pace #(
  parameter int NT = 3,
  parameter int CW = 16,
  parameter int STEP = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_i,
  input  logic [CW-1:0] credit_add_i,
  output logic [NT-1:0] tick_o,
  output logic          sync_req_o
);

  localparam logic [CW-1:0] STEP_C = CW'(STEP);

  logic [CW-1:0] cred_q;

  for (genvar g = 0; g < NT; g++) begin : g_tick
    always_ff @(posedge clk) begin
      if (rst) tick_o[g] <= 1'b0;
      else     tick_o[g] <= bus_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cred_q <= '0;
    else     cred_q <= cred_q - (bus_i ? STEP_C : '0) + credit_add_i;
  end

  assign sync_req_o = cred_q[CW-1];

endmodule

// File: rtl/coproc_mau.sv
module coproc_mau #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SPW = 8,
  parameter int RAM_AW = 11,
  parameter int NT = 3,
  parameter int CW = 16,
  parameter int STEP = 24,
  parameter logic [AW-1:0] RST_PC = 'hFFC0,
  parameter logic [SPW-1:0] RST_SP = 'hEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     op_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           dp_page_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           pc_load_i,
  input  logic [AW-1:0]  pc_val_i,
  input  logic           sp_load_i,
  input  logic [SPW-1:0] sp_val_i,
  input  logic           boot_we_i,
  input  logic           boot_val_i,
  input  logic [CW-1:0]  credit_add_i,
  input  logic [DW-1:0]  mmio_rdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [AW-1:0]  addr_o,
  output logic           mmio_re_o,
  output logic           mmio_we_o,
  output logic [3:0]     mmio_idx_o,
  output logic [DW-1:0]  mmio_wdata_o,
  output logic [AW-1:0]  pc_o,
  output logic [SPW-1:0] sp_o,
  output logic           boot_en_o,
  output logic [NT-1:0]  tick_o,
  output logic           sync_req_o
);

  logic [AW-1:0] ea;
  logic          rd, wr, bus;
  logic          boot_q;

  always_ff @(posedge clk) begin
    if (rst)            boot_q <= 1'b1;
    else if (boot_we_i) boot_q <= boot_val_i;
  end
  assign boot_en_o = boot_q;

  mau_addr #(.AW(AW), .SPW(SPW), .RST_PC(RST_PC), .RST_SP(RST_SP)) u_addr (
    .clk(clk), .rst(rst), .op_i(op_i), .addr_i(addr_i), .dp_page_i(dp_page_i),
    .pc_load_i(pc_load_i), .pc_val_i(pc_val_i), .sp_load_i(sp_load_i),
    .sp_val_i(sp_val_i), .ea_o(ea), .rd_o(rd), .wr_o(wr), .bus_o(bus),
    .pc_o(pc_o), .sp_o(sp_o)
  );

  mau_store #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW)) u_store (
    .clk(clk), .ea_i(ea), .rd_i(rd), .wr_i(wr), .wdata_i(wdata_i),
    .boot_en_i(boot_q), .mmio_rdata_i(mmio_rdata_i), .rdata_o(rdata_o),
    .mmio_re_o(mmio_re_o), .mmio_we_o(mmio_we_o), .mmio_idx_o(mmio_idx_o),
    .mmio_wdata_o(mmio_wdata_o)
  );

  mau_pace #(.NT(NT), .CW(CW), .STEP(STEP)) u_pace (
    .clk(clk), .rst(rst), .bus_i(bus), .credit_add_i(credit_add_i),
    .tick_o(tick_o), .sync_req_o(sync_req_o)
  );

  assign addr_o = ea;

endmodule

// File: rtl/coproc_mau_chk.sv
module coproc_mau_chk #(
  parameter int AW = 16,
  parameter int SPW = 8,
  parameter int NT = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [3:0]     op_i,
  input logic           pc_load_i,
  input logic           sp_load_i,
  input logic [AW-1:0]  pc_o,
  input logic [SPW-1:0] sp_o,
  input logic [NT-1:0]  tick_o,
  input logic           mmio_re_o,
  input logic           mmio_we_o,
  input logic [AW-1:0]  addr_o
);

  logic bus_op, wr_op;
  assign bus_op = (op_i >= 4'd1) && (op_i <= 4'd8);
  assign wr_op  = (op_i == 4'd4) || (op_i == 4'd6) || (op_i == 4'd7);

  assert_tick_on_R9: assert property (@(posedge clk) disable iff (rst)
    bus_op |=> (&tick_o));

  assert_tick_off_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_op |=> (tick_o == '0));

  assert_push_dec_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd7 && !sp_load_i) |=> (sp_o == $past(sp_o) - 1'b1));

  assert_pop_inc_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd8 && !sp_load_i) |=> (sp_o == $past(sp_o) + 1'b1));

  assert_fetch_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2 && !pc_load_i) |=> (pc_o == $past(pc_o) + 1'b1));

  assert_win_we_R4: assert property (@(posedge clk) disable iff (rst)
    mmio_we_o |-> (wr_op && addr_o[AW-1:4] == (AW-4)'(12'h00F)));

  assert_win_excl_R2: assert property (@(posedge clk) disable iff (rst)
    mmio_re_o |-> !mmio_we_o);

endmodule

bind coproc_mau coproc_mau_chk #(.AW(AW), .SPW(SPW), .NT(NT)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .pc_load_i(pc_load_i),
  .sp_load_i(sp_load_i), .pc_o(pc_o), .sp_o(sp_o), .tick_o(tick_o),
  .mmio_re_o(mmio_re_o), .mmio_we_o(mmio_we_o), .addr_o(addr_o)
);

// File: tb/tb_coproc_mau.sv
module tb_coproc_mau;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_i;
  logic [15:0] addr_i;
  logic        dp_page_i;
  logic [7:0]  wdata_i;
  logic        pc_load_i;
  logic [15:0] pc_val_i;
  logic        sp_load_i;
  logic [7:0]  sp_val_i;
  logic        boot_we_i;
  logic        boot_val_i;
  logic [15:0] credit_add_i;
  logic [7:0]  mmio_rdata_i;
  logic [7:0]  rdata_o;
  logic [15:0] addr_o;
  logic        mmio_re_o, mmio_we_o;
  logic [3:0]  mmio_idx_o;
  logic [7:0]  mmio_wdata_o;
  logic [15:0] pc_o;
  logic [7:0]  sp_o;
  logic        boot_en_o;
  logic [2:0]  tick_o;
  logic        sync_req_o;

  always #4 clk = ~clk;

  coproc_mau dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0]  m_ram [2048];
  logic [15:0] m_pc;
  logic [7:0]  m_sp;
  logic        m_boot;
  int          m_cred;

  function automatic logic [7:0] exp_boot(input logic [5:0] i);
    int v;
    v = (int'(i) * 7) % 256;
    return 8'(v) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_ctl();
    pc_load_i = 0; sp_load_i = 0; boot_we_i = 0;
  endtask

  task automatic check_regs(input string req, input bit bus);
    chk(req, "pc", pc_o, m_pc);
    chk(req, "sp", sp_o, m_sp);
    chk(req, "boot_en", boot_en_o, m_boot);
    chk(req, "tick", tick_o, bus ? 3'b111 : 3'b000);
    chk(req, "sync", sync_req_o, m_cred < 0);
  endtask

  task automatic step(input logic [3:0] op, input logic [15:0] a, input logic pg,
                      input logic [7:0] d, input logic [7:0] mrd, input int add,
                      input string req);
    logic [15:0] ea;
    logic [7:0]  exp;
    bit rd, wr, bus, win, rom;
    @(negedge clk);
    clear_ctl();
    op_i = op; addr_i = a; dp_page_i = pg; wdata_i = d;
    mmio_rdata_i = mrd; credit_add_i = 16'(add);
    rd = 0; wr = 0; bus = 1; ea = a;
    case (op)
      4'd1: ;
      4'd2: begin ea = m_pc; rd = 1; end
      4'd3: begin ea = {7'd0, pg, a[7:0]}; rd = 1; end
      4'd4: begin ea = {7'd0, pg, a[7:0]}; wr = 1; end
      4'd5: rd = 1;
      4'd6: wr = 1;
      4'd7: begin ea = {8'h01, m_sp}; wr = 1; end
      4'd8: begin ea = {8'h01, 8'(m_sp + 8'd1)}; rd = 1; end
      default: bus = 0;
    endcase
    #1;
    win = (ea[15:4] == 12'h00F);
    rom = (ea >= 16'hFFC0) && m_boot;
    if (rd || wr) chk(req, "addr", addr_o, ea);
    if (rd) begin
      exp = win ? mrd : rom ? exp_boot(ea[5:0]) : m_ram[ea[10:0]];
      chk(req, "rdata", rdata_o, exp);
      chk(req, "mmio_re", mmio_re_o, win);
    end
    if (wr) begin
      chk(req, "mmio_we", mmio_we_o, win);
      if (win) begin
        chk(req, "mmio_wdata", mmio_wdata_o, d);
        chk(req, "mmio_idx", mmio_idx_o, ea[3:0]);
      end
    end
    if (!rd && !wr) begin
      chk(req, "no_mmio_strobe", {mmio_re_o, mmio_we_o}, 2'b00);
    end
    @(posedge clk);
    if (wr) m_ram[ea[10:0]] = d;
    if (op == 4'd2) m_pc = m_pc + 16'd1;
    if (op == 4'd7) m_sp = m_sp - 8'd1;
    if (op == 4'd8) m_sp = m_sp + 8'd1;
    m_cred = m_cred - (bus ? 24 : 0) + add;
    #1;
    check_regs(req, bus);
  endtask

  task automatic ctl(input bit pcl, input logic [15:0] pcv, input bit spl,
                     input logic [7:0] spv, input bit bwe, input bit bv,
                     input string req);
    @(negedge clk);
    op_i = 4'd0; credit_add_i = 16'd0;
    pc_load_i = pcl; pc_val_i = pcv; sp_load_i = spl; sp_val_i = spv;
    boot_we_i = bwe; boot_val_i = bv;
    @(posedge clk);
    if (pcl) m_pc = pcv;
    if (spl) m_sp = spv;
    if (bwe) m_boot = bv;
    #1;
    check_regs(req, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; op_i = 0; addr_i = 0; dp_page_i = 0; wdata_i = 0;
    pc_val_i = 0; sp_val_i = 0; boot_val_i = 0; credit_add_i = 0;
    mmio_rdata_i = 0; clear_ctl();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    m_pc = 16'hFFC0; m_sp = 8'hEF; m_boot = 1; m_cred = 0;
    for (int i = 0; i < 2048; i++) m_ram[i] = 8'h00;
    // R1: reset state
    chk("R1", "pc", pc_o, 16'hFFC0);
    chk("R1", "sp", sp_o, 8'hEF);
    chk("R1", "boot_en", boot_en_o, 1'b1);
    chk("R1", "tick", tick_o, 3'b000);
    chk("R1", "sync", sync_req_o, 1'b0);

    // R3 R7: first fetches come from the overlay
    step(4'd2, 0, 0, 0, 0, 24, "R3_R7");
    step(4'd2, 0, 0, 0, 0, 24, "R3_R7");

    // R4 R11: fill RAM (window range included)
    for (int i = 0; i < 2048; i++)
      step(4'd6, 16'(i), 0, 8'(i * 13 + 5), 8'hEE, 24, "R4");

    // R4 R3 R12: write under overlay, visible only with overlay off
    step(4'd6, 16'hFFC5, 0, 8'h3C, 0, 24, "R4");
    step(4'd5, 16'hFFC5, 0, 0, 0, 24, "R3");
    ctl(0, 0, 0, 0, 1, 0, "R12");
    step(4'd5, 16'hFFC5, 0, 0, 0, 24, "R12");
    step(4'd5, 16'hFFFF, 0, 0, 0, 24, "R3");
    ctl(0, 0, 0, 0, 1, 1, "R12");
    step(4'd5, 16'hFFFF, 0, 0, 0, 24, "R3");

    // R2 R4 R11: window read, window write also lands in RAM (seen via alias)
    step(4'd5, 16'h00F3, 0, 0, 8'h99, 24, "R2");
    step(4'd6, 16'h00F4, 0, 8'h66, 0, 24, "R4");
    step(4'd5, 16'h08F4, 0, 0, 0, 24, "R11");
    step(4'd5, 16'h00F4, 0, 0, 8'h12, 24, "R2");

    // R5: direct page
    step(4'd4, 16'hAB20, 1, 8'h11, 0, 24, "R5");
    step(4'd5, 16'h0120, 0, 0, 0, 24, "R5");
    step(4'd3, 16'h5520, 0, 0, 0, 24, "R5");
    step(4'd3, 16'h00F7, 0, 0, 8'h42, 24, "R5");

    // R6 R8: stack wrap
    ctl(0, 0, 1, 8'h01, 0, 0, "R8");
    step(4'd7, 0, 0, 8'hA1, 0, 24, "R6");
    step(4'd7, 0, 0, 8'hB2, 0, 24, "R6");
    step(4'd7, 0, 0, 8'hC3, 0, 24, "R8");
    step(4'd8, 0, 0, 0, 0, 24, "R8");
    step(4'd8, 0, 0, 0, 0, 24, "R6");
    step(4'd8, 0, 0, 0, 0, 24, "R6");
    ctl(0, 0, 1, 8'hFF, 0, 0, "R8");
    step(4'd8, 0, 0, 0, 0, 24, "R8");

    // R9 R10: idle and no-bus cycles, credit sign
    step(4'd1, 0, 0, 0, 0, 0, "R9");
    step(4'd0, 0, 0, 0, 0, 0, "R9");
    step(4'd12, 16'h0300, 0, 8'h77, 0, 0, "R9");
    step(4'd5, 16'h0300, 0, 0, 0, 24, "R9");
    for (int i = 0; i < 4; i++) step(4'd1, 0, 0, 0, 0, 0, "R10");
    step(4'd0, 0, 0, 0, 0, 200, "R10");
    step(4'd1, 0, 0, 0, 0, 0, "R10");

    // R7: PC load then fetch from RAM
    ctl(1, 16'h0345, 0, 0, 0, 0, "R7");
    step(4'd2, 0, 0, 0, 0, 24, "R7");
    step(4'd2, 0, 0, 0, 0, 24, "R7");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r, k;
      logic [15:0] a;
      r = $urandom_range(0, 99);
      k = $urandom_range(0, 3);
      a = 16'($urandom);
      if (k == 0) a = {12'h00F, 4'($urandom)};
      else if (k == 1) a = {10'h3FF, 6'($urandom)};
      if (r < 4) ctl(1, 16'($urandom), 1, 8'($urandom), 1, 1'($urandom), "R7_R8_R12");
      else step(4'($urandom_range(0, 10)), a, 1'($urandom), 8'($urandom),
                8'($urandom), $urandom_range(0, 48), "R2_R3_R4_R5_R6_R9_R10");
    end

    @(negedge clk); op_i = 4'd0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule